// File: doc/BRIEF.md
# DDS Serial Load Controller

This block drives the control pins of a direct digital synthesizer that is programmed through a 40-bit serial control word. A one-cycle start request makes it run the full bring-up. It pulses the synthesizer's reset output, waits out the required quiet time, and then performs the load that switches the part into serial mode. That load presents a fixed pattern on three parallel data pins and gives one write-clock pulse followed by one update-strobe pulse.

Once bring-up is done, the block takes commands on a valid/ready port. Each command carries a 32-bit frequency tuning value, a power-down flag and a 5-bit phase code. The block assembles the 40-bit word and shifts it out on a data line, least significant bit first, with a write clock that is derived from the system clock. It then pulses the update strobe to commit the word. Timing is set in system-clock cycles by three parameters: the half period of the write clock, the width of the reset pulse, and the gap after reset.

Top module: `dds_serial_loader`

## Requirements
- R1: After the block's own reset, and until the first start request, the reset, write clock, data and update outputs are low, the pattern output is 3'b000 and ready is low.
- R2: A start request sampled at a clock edge drives the synthesizer reset output high from the next cycle, for exactly RST_PULSE_CYC cycles.
- R3: After the reset output falls, the write clock and the update strobe stay low for exactly RST_GAP_CYC cycles.
- R4: The serial-enable load follows, in order: the write clock high for HALF_CYC cycles, then low for HALF_CYC cycles, then the update strobe high for HALF_CYC cycles, then low for HALF_CYC cycles. During the write-clock pulse the pattern output is 3'b011 (bit 0 = D0 = 1, bit 1 = D1 = 1, bit 2 = D2 = 0). Ready rises when the load ends, and the pattern returns to 3'b000.
- R5: The word sent for a command has bits 31..0 equal to the frequency value, bits 33..32 equal to 0, bit 34 equal to the power-down flag, and bits 39..35 equal to the phase code.
- R6: The word goes out bit 0 first and bit 39 last, on exactly 40 write-clock rising edges. Each bit is placed with the clock low for HALF_CYC cycles before its rising edge, and it is held through a HALF_CYC-cycle high phase.
- R7: After the 40th bit's high phase, and with the write clock low, the update strobe goes high for HALF_CYC cycles. Ready returns HALF_CYC cycles after the strobe falls. The write clock and the strobe are never high together.
- R8: A command is taken only when valid and ready are both high. Ready is low from the cycle after capture until the strobe has returned low. Commands presented before bring-up has finished are ignored.
- R9: A start request at any time, including during a transfer, restarts the whole bring-up from R2. An interrupted word is never committed.
- R10: While ready is high, the reset, write clock, data and update outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset of the block |
| start_i | input | 1 | Request to run the reset and serial-enable bring-up |
| cmd_valid_i | input | 1 | Command valid |
| cmd_ready_o | output | 1 | Command ready; high only when idle and no start is requested |
| cmd_ftw_i | input | 32 | Frequency tuning value |
| cmd_pdown_i | input | 1 | Power-down flag |
| cmd_phase_i | input | 5 | Phase code |
| dds_reset_o | output | 1 | Synthesizer master reset |
| dds_wclk_o | output | 1 | Write clock, idles low |
| dds_data_o | output | 1 | Serial data line |
| dds_fqud_o | output | 1 | Frequency-update strobe, idles low |
| dds_pattern_o | output | 3 | Parallel pins D2..D0 used for the serial-enable load |

## Verification
Every output is decoded directly from registered state, so it changes in the first cycle after the edge that samples start_i or a valid/ready handshake. The reset pulse is then due from that cycle. The gap follows after RST_PULSE_CYC cycles, and each write-clock and strobe phase lasts HALF_CYC cycles. The bench samples on the falling clock edge and measures the length of every run of a level, comparing it with those exact counts instead of polling for a level. A shifted word is rebuilt from the data seen at each sampled rising write-clock edge. The strobe width and the delay until ready returns are counted from the sample where the strobe falls.

// File: rtl/dds_ser_pkg.sv
package dds_ser_pkg;

  localparam int WORD_W  = 40;
  localparam int FTW_W   = 32;
  localparam int PHASE_W = 5;

  // D2..D0 levels that select serial mode during the enable load
  localparam logic [2:0] SER_EN_PAT = 3'b011;

  typedef enum logic [3:0] {
    ST_OFF,
    ST_RST_HI,
    ST_RST_GAP,
    ST_EN_WH,
    ST_EN_WL,
    ST_EN_UH,
    ST_EN_UL,
    ST_IDLE,
    ST_BIT_LO,
    ST_BIT_HI,
    ST_UP_HI,
    ST_UP_LO
  } dds_state_e;

  // Control word: tuning value low, two zero bits, power-down, phase on top
  function automatic logic [WORD_W-1:0] pack_word(
    input logic [FTW_W-1:0]   ftw,
    input logic               pdown,
    input logic [PHASE_W-1:0] phase
  );
    return {phase, pdown, 2'b00, ftw};
  endfunction

endpackage

// File: rtl/dds_phase_timer.sv
module dds_phase_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [CNT_W-1:0] len,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  // Last cycle of a phase that lasts len cycles
  assign expired = (cnt_q == len - 1'b1);

endmodule

// File: rtl/dds_word_shifter.sv
module dds_word_shifter #(
  parameter int WORD_W = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic              shift,
  output logic              bit_o,
  output logic              last_o
);

  localparam int IDX_W = $clog2(WORD_W + 1);

  logic [WORD_W-1:0] sr_q;
  logic [IDX_W-1:0]  idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_q  <= '0;
      idx_q <= '0;
    end else if (load) begin
      sr_q  <= load_word;
      idx_q <= '0;
    end else if (shift) begin
      sr_q  <= {1'b0, sr_q[WORD_W-1:1]};
      idx_q <= idx_q + 1'b1;
    end
  end

  assign bit_o  = sr_q[0];
  assign last_o = (idx_q == IDX_W'(WORD_W - 1));

endmodule

// File: rtl/dds_serial_loader.sv
module dds_serial_loader
  import dds_ser_pkg::*;
#(
  parameter int HALF_CYC      = 2,
  parameter int RST_PULSE_CYC = 8,
  parameter int RST_GAP_CYC   = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         cmd_valid_i,
  output logic         cmd_ready_o,
  input  logic [31:0]  cmd_ftw_i,
  input  logic         cmd_pdown_i,
  input  logic [4:0]   cmd_phase_i,
  output logic         dds_reset_o,
  output logic         dds_wclk_o,
  output logic         dds_data_o,
  output logic         dds_fqud_o,
  output logic [2:0]   dds_pattern_o
);

  localparam int LONG_A  = (RST_PULSE_CYC > RST_GAP_CYC) ? RST_PULSE_CYC : RST_GAP_CYC;
  localparam int LONGEST = (LONG_A > HALF_CYC) ? LONG_A : HALF_CYC;
  localparam int CNT_W   = $clog2(LONGEST + 1);

  dds_state_e       state_q, state_d;
  logic [CNT_W-1:0] tmr_len;
  logic             tmr_exp;
  logic             tmr_restart;
  logic             accept_w;
  logic             bit_shift_w;
  logic             shift_bit;
  logic             shift_last;
  logic             in_enable;
  logic             in_xfer;

  assign cmd_ready_o = (state_q == ST_IDLE) && !start_i;
  assign accept_w    = cmd_valid_i && cmd_ready_o;

  always_comb begin
    case (state_q)
      ST_RST_HI:  tmr_len = CNT_W'(RST_PULSE_CYC);
      ST_RST_GAP: tmr_len = CNT_W'(RST_GAP_CYC);
      default:    tmr_len = CNT_W'(HALF_CYC);
    endcase
  end

  always_comb begin
    state_d = state_q;
    if (start_i) begin
      state_d = ST_RST_HI;
    end else begin
      case (state_q)
        ST_OFF:     state_d = ST_OFF;
        ST_RST_HI:  if (tmr_exp) state_d = ST_RST_GAP;
        ST_RST_GAP: if (tmr_exp) state_d = ST_EN_WH;
        ST_EN_WH:   if (tmr_exp) state_d = ST_EN_WL;
        ST_EN_WL:   if (tmr_exp) state_d = ST_EN_UH;
        ST_EN_UH:   if (tmr_exp) state_d = ST_EN_UL;
        ST_EN_UL:   if (tmr_exp) state_d = ST_IDLE;
        ST_IDLE:    if (accept_w) state_d = ST_BIT_LO;
        ST_BIT_LO:  if (tmr_exp) state_d = ST_BIT_HI;
        ST_BIT_HI:  if (tmr_exp) state_d = shift_last ? ST_UP_HI : ST_BIT_LO;
        ST_UP_HI:   if (tmr_exp) state_d = ST_UP_LO;
        ST_UP_LO:   if (tmr_exp) state_d = ST_IDLE;
        default:    state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_OFF;
    else        state_q <= state_d;
  end

  // Every phase, including a repeated reset phase, starts its count afresh
  assign tmr_restart = start_i || (state_d != state_q);
  assign bit_shift_w = (state_q == ST_BIT_HI) && tmr_exp && !start_i;

  dds_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (tmr_restart),
    .len     (tmr_len),
    .expired (tmr_exp)
  );

  dds_word_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept_w),
    .load_word (pack_word(cmd_ftw_i, cmd_pdown_i, cmd_phase_i)),
    .shift     (bit_shift_w),
    .bit_o     (shift_bit),
    .last_o    (shift_last)
  );

  assign in_enable = (state_q == ST_EN_WH) || (state_q == ST_EN_WL) ||
                     (state_q == ST_EN_UH) || (state_q == ST_EN_UL);
  assign in_xfer   = (state_q == ST_BIT_LO) || (state_q == ST_BIT_HI);

  assign dds_reset_o   = (state_q == ST_RST_HI);
  assign dds_wclk_o    = (state_q == ST_EN_WH) || (state_q == ST_BIT_HI);
  assign dds_fqud_o    = (state_q == ST_EN_UH) || (state_q == ST_UP_HI);
  assign dds_data_o    = in_xfer && shift_bit;
  assign dds_pattern_o = in_enable ? SER_EN_PAT : 3'b000;

endmodule

// File: rtl/dds_loader_chk.sv
module dds_loader_chk
  import dds_ser_pkg::*;
#(
  parameter int RST_GAP_CYC = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       accept_w,
  input logic       cmd_ready_o,
  input logic       dds_reset_o,
  input logic       dds_wclk_o,
  input logic       dds_data_o,
  input logic       dds_fqud_o,
  input logic [2:0] dds_pattern_o
);

  logic [5:0]  rise_cnt_q;
  logic        wclk_prev_q;
  logic [15:0] gap_cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rise_cnt_q  <= '0;
      wclk_prev_q <= 1'b0;
      gap_cnt_q   <= '0;
    end else begin
      wclk_prev_q <= dds_wclk_o;
      if (accept_w)
        rise_cnt_q <= '0;
      else if (dds_wclk_o && !wclk_prev_q && rise_cnt_q != 6'h3f)
        rise_cnt_q <= rise_cnt_q + 1'b1;
      if (dds_reset_o)
        gap_cnt_q <= '0;
      else if (gap_cnt_q != 16'hffff)
        gap_cnt_q <= gap_cnt_q + 1'b1;
    end
  end

  AST_START_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> dds_reset_o); // R9
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    dds_reset_o |-> (!dds_wclk_o && !dds_fqud_o)); // R2
  AST_GAP_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (dds_wclk_o || dds_fqud_o) |-> (gap_cnt_q >= 16'(RST_GAP_CYC))); // R3
  AST_DATA_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (dds_wclk_o && $past(dds_wclk_o)) |-> $stable(dds_data_o)); // R6
  AST_COMMIT_AFTER_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dds_fqud_o) && dds_pattern_o == 3'b000) |-> (rise_cnt_q == 6'(WORD_W))); // R6
  AST_ENABLE_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dds_fqud_o) && dds_pattern_o != 3'b000 |-> dds_pattern_o == SER_EN_PAT); // R4
  AST_NO_CLK_STROBE_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(dds_wclk_o && dds_fqud_o)); // R7
  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |=> !cmd_ready_o); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready_o |-> (!dds_reset_o && !dds_wclk_o && !dds_fqud_o && !dds_data_o)); // R10

endmodule

bind dds_serial_loader dds_loader_chk #(.RST_GAP_CYC(RST_GAP_CYC)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .start_i       (start_i),
  .accept_w      (accept_w),
  .cmd_ready_o   (cmd_ready_o),
  .dds_reset_o   (dds_reset_o),
  .dds_wclk_o    (dds_wclk_o),
  .dds_data_o    (dds_data_o),
  .dds_fqud_o    (dds_fqud_o),
  .dds_pattern_o (dds_pattern_o)
);

// File: tb/test_dds_serial_loader.sv
module test_dds_serial_loader;

  localparam int H = 2;
  localparam int P = 8;
  localparam int G = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        valid = 1'b0;
  logic        ready;
  logic [31:0] ftw = '0;
  logic        pdown = 1'b0;
  logic [4:0]  phase = '0;
  logic        d_rst, d_wclk, d_data, d_fqud;
  logic [2:0]  d_pat;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dds_serial_loader #(.HALF_CYC(H), .RST_PULSE_CYC(P), .RST_GAP_CYC(G)) i_dds_serial_loader (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start),
    .cmd_valid_i   (valid),
    .cmd_ready_o   (ready),
    .cmd_ftw_i     (ftw),
    .cmd_pdown_i   (pdown),
    .cmd_phase_i   (phase),
    .dds_reset_o   (d_rst),
    .dds_wclk_o    (d_wclk),
    .dds_data_o    (d_data),
    .dds_fqud_o    (d_fqud),
    .dds_pattern_o (d_pat)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic quiet_outputs(input string req);
    check(!d_rst && !d_wclk && !d_data && !d_fqud, req, "outputs quiet",
          {d_rst, d_wclk, d_data, d_fqud}, 0);
  endtask

  task automatic test_reset_state;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    quiet_outputs("R1");
    check(ready == 1'b0, "R1", "ready after reset", ready, 0);
    check(d_pat == 3'b000, "R1", "pattern after reset", d_pat, 0);
  endtask

  task automatic test_ignore_before_init;
    bit seen = 0;
    valid = 1'b1;
    ftw   = 32'h1234_5678;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (ready || d_wclk || d_fqud || d_rst) seen = 1;
    end
    valid = 1'b0;
    check(!seen, "R8", "command before bring-up ignored", seen, 0);
    quiet_outputs("R1");
  endtask

  // Pulses start and measures every phase of the bring-up
  task automatic do_init;
    int n;
    bit pat_ok;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check(d_rst == 1'b1, "R2", "reset high one cycle after start", d_rst, 1);
    check(ready == 1'b0, "R8", "ready low during bring-up", ready, 0);
    n = 0;
    while (d_rst && n < 1000) begin n++; @(negedge clk); end
    check(n == P, "R2", "reset pulse width", n, P);
    n = 0;
    while (!d_wclk && !d_fqud && !d_rst && n < 1000) begin n++; @(negedge clk); end
    check(n == G, "R3", "quiet gap after reset", n, G);
    n = 0; pat_ok = 1;
    while (d_wclk && n < 1000) begin
      if (d_pat != 3'b011) pat_ok = 0;
      n++; @(negedge clk);
    end
    check(n == H, "R4", "enable write-clock high", n, H);
    check(pat_ok, "R4", "pattern 011 during enable clock", d_pat, 3);
    n = 0;
    while (!d_wclk && !d_fqud && n < 1000) begin n++; @(negedge clk); end
    check(n == H, "R4", "enable write-clock low", n, H);
    n = 0;
    while (d_fqud && n < 1000) begin n++; @(negedge clk); end
    check(n == H, "R4", "enable strobe high", n, H);
    n = 0;
    while (!ready && n < 1000) begin n++; @(negedge clk); end
    check(n == H, "R4", "enable strobe low until ready", n, H);
    check(d_pat == 3'b000, "R4", "pattern released", d_pat, 0);
  endtask

  task automatic issue_cmd(input logic [31:0] f, input logic pd, input logic [4:0] ph);
    int g = 0;
    @(negedge clk);
    valid = 1'b1; ftw = f; pdown = pd; phase = ph;
    while (!ready && g < 1000) begin g++; @(negedge clk); end
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic send_cmd(input logic [31:0] f, input logic pd, input logic [4:0] ph);
    logic [39:0] exp_w, got;
    int nr = 0, lowrun = 0, hr = 0, fh = 0, n = 0, g = 0;
    bit pw = 0, pf = 0, pdat, tbad = 0, sbad = 0, rbad = 0, obad = 0, done = 0;
    exp_w = '0;
    for (int i = 0; i < 32; i++) exp_w[i] = f[i];
    exp_w[34] = pd;
    for (int i = 0; i < 5; i++) exp_w[35 + i] = ph[i];
    got = '0;
    issue_cmd(f, pd, ph);
    pdat = d_data;
    while (!done && g < 2000) begin
      g++;
      if (ready) rbad = 1;
      if (d_wclk) begin
        if (!pw) begin
          if (lowrun != H) tbad = 1;
          if (d_data != pdat) sbad = 1;
          if (nr < 40) got[nr] = d_data;
          nr++; hr = 1;
        end else begin
          hr++;
          if (d_data != pdat) sbad = 1;
        end
      end else begin
        if (pw) begin
          if (hr != H) tbad = 1;
          lowrun = 1;
        end else lowrun++;
      end
      if (d_fqud) begin
        fh++;
        if (nr != 40 || d_wclk) obad = 1;
      end
      if (!d_fqud && pf) done = 1;
      pw = d_wclk; pf = d_fqud; pdat = d_data;
      if (!done) @(negedge clk);
    end
    check(nr == 40, "R6", "write-clock rising edges", nr, 40);
    check(got == exp_w, "R5", "assembled word LSB first", got, exp_w);
    check(!tbad, "R6", "low/high phase lengths", tbad, 0);
    check(!sbad, "R6", "data stable around rising edge", sbad, 0);
    check(!obad, "R7", "strobe only after last bit, clock low", obad, 0);
    check(fh == H, "R7", "commit strobe width", fh, H);
    check(!rbad, "R8", "ready low until strobe falls", rbad, 0);
    while (!ready && n < 1000) begin n++; @(negedge clk); end
    check(n == H, "R7", "ready after strobe falls", n, H);
  endtask

  task automatic test_idle_quiet;
    bit bad = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (!ready || d_rst || d_wclk || d_data || d_fqud) bad = 1;
    end
    check(!bad, "R10", "idle outputs low with ready high", bad, 0);
  endtask

  task automatic test_restart_mid_transfer;
    bit strobe = 0;
    issue_cmd(32'hFFFF_FFFF, 1'b1, 5'h1f);
    for (int i = 0; i < 25; i++) begin
      @(negedge clk);
      if (d_fqud) strobe = 1;
    end
    check(!strobe, "R9", "no strobe before restart", strobe, 0);
    check(ready == 1'b0, "R9", "busy when restart requested", ready, 0);
    do_init();
  endtask

  initial begin
    test_reset_state();
    test_ignore_before_init();
    do_init();
    send_cmd(32'h0000_0001, 1'b0, 5'h00);
    test_idle_quiet();
    send_cmd(32'hA5A5_5A5A, 1'b1, 5'h15);
    send_cmd(32'hFFFF_FFFF, 1'b1, 5'h1f);
    send_cmd(32'h8000_0000, 1'b0, 5'h10);
    test_restart_mid_transfer();
    send_cmd(32'h0F0F_3C3C, 1'b0, 5'h0a);
    do_init();
    send_cmd(32'h0000_0000, 1'b1, 5'h01);
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule